// File: doc/BRIEF.md
# Two-Level Ready Bitmap Scheduler

This block tracks which of 64 prioritized tasks are ready to run and reports the most urgent one. Priority 0 is the most urgent and 63 the least. Ready state is held as eight 8-bit rows. An 8-bit summary register marks which rows hold at least one ready task. Each cycle, a caller can mark one priority ready with the set command and withdraw one with the clear command.

The most urgent ready priority is found in two steps. The first step takes the lowest set bit of the summary as the row index y. The second step takes the lowest set bit of row y as the column x. The result is y*8 + x. Priority 63 is reserved for an always-ready idle task, so a result always exists once the block has left reset.

The control sequence has two named states. ST_BOOT is entered on reset; in it `top_valid` is low. The transition boot_done is taken unconditionally on the first clock edge after reset is released and leads to ST_RUN. ST_RUN is held until the next reset; in it `top_valid` is high and `top_prio` is reloaded every cycle. The lookup reads the table as it will be after the current cycle's commands. This means a command is reflected at the outputs on the cycle after the edge that samples it.

Top module: `rdy_sched`

## Requirements
- R1: While `rst_n` is low, `top_valid` is 0. Reset empties every entry except priority 63. After the first rising edge with `rst_n` high, `top_valid` is 1 and `top_prio` is 63.
- R2: A priority p maps to row p[5:2+1] (bits 5..3) and column p[2:0]. Row r is also summary bit r. For example, priority 24 sits in row 3, column 0.
- R3: A set command with priority p makes p ready. From the edge that samples it, `top_prio` reports p if no more urgent task is ready.
- R4: A clear command with priority p removes p from the ready set. From the edge that samples it, `top_prio` no longer reports p.
- R5: A summary bit is cleared only when its whole row becomes empty. Clearing one entry of a row that still holds another leaves that other entry reported.
- R6: `top_prio` is the numerically lowest ready priority. A row value of 0x06 resolves to column 1, and 0x20 resolves to column 5.
- R7: When set and clear name the same priority in the same cycle, the clear wins. This holds whether or not that priority was already ready.
- R8: When set and clear name different priorities in the same cycle, both take effect.
- R9: A clear of priority 63 has no effect; the idle entry stays ready.
- R10: Once `top_valid` is 1, it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_en | input | 1 | Mark `set_prio` ready this cycle |
| set_prio | input | 6 | Priority to mark ready |
| clr_en | input | 1 | Withdraw `clr_prio` this cycle |
| clr_prio | input | 6 | Priority to withdraw |
| top_prio | output | 6 | Most urgent ready priority (registered) |
| top_valid | output | 1 | High once the idle entry is installed after reset |

## Verification
A set and a clear can arrive in the same cycle. The vectors drive both commands together in two ways: on one shared priority (both when it was idle and when it was already ready) and on two different priorities in one row or in different rows. Each outcome is judged by the reported priority on the following cycle. That value shows whether the entry survived and whether the row summary still matches the row contents.

// File: rtl/rdy_pkg.sv
package rdy_pkg;
    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } sched_state_e;
endpackage

// File: rtl/rdy_lsb_find.sv
module rdy_lsb_find #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/rdy_row_bank.sv
module rdy_row_bank #(
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3,
    parameter int NROW     = 1 << ROW_BITS,
    parameter int NCOL     = 1 << COL_BITS,
    parameter int PRIO_W   = ROW_BITS + COL_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_en,
    input  logic [PRIO_W-1:0]      set_prio,
    input  logic                   clr_en,
    input  logic [PRIO_W-1:0]      clr_prio,
    output logic [NROW*NCOL-1:0]   bits_nxt,
    output logic [NROW*NCOL-1:0]   bits_q,
    output logic [NROW-1:0]        grp_nxt
);
    localparam int NENT = NROW * NCOL;
    localparam logic [PRIO_W-1:0] IDLE = PRIO_W'(NENT - 1);

    logic [NROW-1:0]     grp_q;
    logic [ROW_BITS-1:0] set_row, clr_row;
    logic [COL_BITS-1:0] set_col, clr_col;
    logic                clr_ok;

    assign set_row = set_prio[PRIO_W-1 -: ROW_BITS];
    assign set_col = set_prio[COL_BITS-1:0];
    assign clr_row = clr_prio[PRIO_W-1 -: ROW_BITS];
    assign clr_col = clr_prio[COL_BITS-1:0];
    assign clr_ok  = clr_en && (clr_prio != IDLE);

    for (genvar r = 0; r < NROW; r++) begin : g_row
        logic [NCOL-1:0] row_q, set_m, clr_m, row_n;
        assign row_q = bits_q[r*NCOL +: NCOL];
        assign set_m = (set_en && set_row == ROW_BITS'(r)) ? (NCOL'(1) << set_col) : '0;
        assign clr_m = (clr_ok && clr_row == ROW_BITS'(r)) ? (NCOL'(1) << clr_col) : '0;
        assign row_n = (row_q | set_m) & ~clr_m;
        assign bits_nxt[r*NCOL +: NCOL] = row_n;
        assign grp_nxt[r] = (grp_q[r] | (|set_m)) & ~((|clr_m) && (row_n == '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= NENT'(1) << (NENT - 1);
            grp_q  <= NROW'(1) << (NROW - 1);
        end else begin
            bits_q <= bits_nxt;
            grp_q  <= grp_nxt;
        end
    end

    // R5: each summary bit matches whether its row holds a ready entry
    for (genvar r = 0; r < NROW; r++) begin : g_chk
        a_r5_summary_matches_row: assert property (@(posedge clk) disable iff (!rst_n)
            grp_q[r] == (|bits_q[r*NCOL +: NCOL]));
    end

    a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !(clr_en && clr_prio == set_prio)) |=> bits_q[$past(set_prio)]);

    a_r4_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_prio != IDLE) |=> !bits_q[$past(clr_prio)]);

    a_r9_idle_kept: assert property (@(posedge clk) disable iff (!rst_n)
        bits_q[NENT-1] && grp_q[NROW-1]);
endmodule

// File: rtl/rdy_sched.sv
module rdy_sched #(
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3,
    parameter int PRIO_W   = ROW_BITS + COL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [PRIO_W-1:0] set_prio,
    input  logic              clr_en,
    input  logic [PRIO_W-1:0] clr_prio,
    output logic [PRIO_W-1:0] top_prio,
    output logic              top_valid
);
    import rdy_pkg::*;

    localparam int NROW = 1 << ROW_BITS;
    localparam int NCOL = 1 << COL_BITS;
    localparam int NENT = NROW * NCOL;

    logic [NENT-1:0]     bits_nxt, bits_q;
    logic [NROW-1:0]     grp_nxt;
    logic [ROW_BITS-1:0] y_idx;
    logic [COL_BITS-1:0] x_idx;
    logic [NCOL-1:0]     sel_row;
    sched_state_e        state_q, state_d;

    rdy_row_bank #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (set_en),
        .set_prio (set_prio),
        .clr_en   (clr_en),
        .clr_prio (clr_prio),
        .bits_nxt (bits_nxt),
        .bits_q   (bits_q),
        .grp_nxt  (grp_nxt)
    );

    rdy_lsb_find #(.W(NROW)) u_find_row (.vec(grp_nxt), .idx(y_idx));

    assign sel_row = bits_nxt[y_idx*NCOL +: NCOL];

    rdy_lsb_find #(.W(NCOL)) u_find_col (.vec(sel_row), .idx(x_idx));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_prio  <= '0;
            top_valid <= 1'b0;
        end else begin
            unique case (state_q)
                ST_BOOT: begin
                    top_valid <= 1'b1;
                    top_prio  <= {y_idx, x_idx};
                end
                ST_RUN: begin
                    top_valid <= 1'b1;
                    top_prio  <= {y_idx, x_idx};
                end
            endcase
        end
    end

    a_r10_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |=> top_valid);

    a_r6_top_is_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |-> (bits_q[top_prio] &&
                       ((bits_q & ((NENT'(1) << top_prio) - NENT'(1))) == '0)));

    a_r1_run_after_boot: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> top_valid);
endmodule

// File: tb/tb_rdy_sched.sv
`timescale 1ns/1ps
module tb_rdy_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_en = 1'b0;
    logic [5:0] set_prio = '0;
    logic       clr_en = 1'b0;
    logic [5:0] clr_prio = '0;
    logic [5:0] top_prio;
    logic       top_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rdy_sched dut (
        .clk(clk), .rst_n(rst_n),
        .set_en(set_en), .set_prio(set_prio),
        .clr_en(clr_en), .clr_prio(clr_prio),
        .top_prio(top_prio), .top_valid(top_valid)
    );

    // {set_en, set_prio, clr_en, clr_prio, expected top_prio}
    localparam int NV = 26;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 6'd24, 1'b0, 6'd0,  6'd24}, // R2 R3: row 3 col 0
        {1'b1, 6'd30, 1'b0, 6'd0,  6'd24}, // R6
        {1'b1, 6'd9,  1'b0, 6'd0,  6'd9 }, // R3
        {1'b0, 6'd0,  1'b1, 6'd9,  6'd24}, // R4
        {1'b0, 6'd0,  1'b1, 6'd24, 6'd30}, // R5: row 3 keeps 30
        {1'b1, 6'd5,  1'b1, 6'd30, 6'd5 }, // R8 different rows
        {1'b1, 6'd2,  1'b1, 6'd2,  6'd5 }, // R7 clear wins, not ready before
        {1'b1, 6'd1,  1'b1, 6'd5,  6'd1 }, // R8 same row
        {1'b1, 6'd2,  1'b1, 6'd1,  6'd2 }, // R8
        {1'b0, 6'd0,  1'b1, 6'd2,  6'd63}, // R5 row empties
        {1'b0, 6'd0,  1'b1, 6'd63, 6'd63}, // R9
        {1'b1, 6'd62, 1'b0, 6'd0,  6'd62}, // R3
        {1'b1, 6'd57, 1'b0, 6'd0,  6'd57}, // R6
        {1'b0, 6'd0,  1'b1, 6'd57, 6'd62}, // R4
        {1'b0, 6'd0,  1'b1, 6'd62, 6'd63}, // R9 row 7 still holds idle
        {1'b1, 6'd34, 1'b0, 6'd0,  6'd34}, // R3
        {1'b1, 6'd33, 1'b0, 6'd0,  6'd33}, // R6 row 0x06 -> col 1
        {1'b0, 6'd0,  1'b1, 6'd33, 6'd34}, // R5
        {1'b0, 6'd0,  1'b1, 6'd34, 6'd63}, // R4
        {1'b1, 6'd45, 1'b0, 6'd0,  6'd45}, // R6 row 0x20 -> col 5
        {1'b0, 6'd0,  1'b1, 6'd45, 6'd63}, // R4
        {1'b1, 6'd0,  1'b0, 6'd0,  6'd0 }, // R6 most urgent
        {1'b0, 6'd0,  1'b1, 6'd0,  6'd63}, // R4
        {1'b1, 6'd10, 1'b0, 6'd0,  6'd10}, // R3
        {1'b1, 6'd10, 1'b1, 6'd10, 6'd63}, // R7 clear wins, already ready
        {1'b0, 6'd0,  1'b1, 6'd63, 6'd63}  // R9
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(top_valid == 1'b0, "R1 valid low in reset", top_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(top_valid == 1'b1, "R1 valid after boot", top_valid, 1);
        check(top_prio == 6'd63, "R1 idle after boot", top_prio, 63);

        for (int i = 0; i < NV; i++) begin
            {set_en, set_prio, clr_en, clr_prio} = VEC[i][19:6];
            @(negedge clk);
            set_en = 1'b0;
            clr_en = 1'b0;
            check(top_prio == VEC[i][5:0], $sformatf("R6 vector %0d", i),
                  top_prio, VEC[i][5:0]);
            check(top_valid == 1'b1, "R10 valid held", top_valid, 1);
        end

        // R1: reset mid-run drops all non-idle entries
        set_en = 1'b1; set_prio = 6'd3;
        @(negedge clk);
        set_en = 1'b0;
        check(top_prio == 6'd3, "R3 before reset", top_prio, 3);
        rst_n = 1'b0;
        #1;
        check(top_valid == 1'b0, "R1 valid low in second reset", top_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(top_valid == 1'b1 && top_prio == 6'd63, "R1 table emptied by reset",
              top_prio, 63);

        // R10: idle output holds over quiet cycles
        repeat (4) @(negedge clk);
        check(top_valid == 1'b1 && top_prio == 6'd63, "R10 quiet hold", top_prio, 63);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule